// File: doc/BRIEF.md
# Adaptive Threshold Bit-Flip Variable Node

This block is the per-bit variable node of a hard-decision LDPC decoder that decides bit flips locally with adaptive thresholds. At the start of a frame it captures one sign-magnitude soft value from the channel and keeps it in a register for the whole frame. On each iteration it combines that value with the bipolar syndromes of the parity checks it belongs to. The result is an inversion metric. The node then does one of two things: it flips its hard decision, or it moves its own negative threshold one arithmetic right shift towards zero.

No search for a minimum across the block is needed. Each node reaches its decision alone from its threshold. When the threshold climbs to a preset flipping threshold, the node goes quiescent. It then holds its state until the next frame, and it pulses a flag that frame-level logic can use to stop decoding early. Check-node parity logic, edge routing and iteration control are outside this block.

Top module: `atbf_var_node`

## Requirements
- R1: While `rst` is high at a clock edge, `hd_out`, `quiet` and `thr_hit` all become 0.
- R2: A `frame_start` pulse loads `hd_out` from bit 3 of `ch_soft`, the sign bit, where 1 means hard decision 1. It also clears `quiet`.
- R3: The channel value used in every iteration is the one captured at the last `frame_start`. Later changes on `ch_soft` have no effect until the next frame starts.
- R4: The correlation term is the magnitude `ch_soft[2:0]` when the current hard decision equals the captured sign bit, and its negative otherwise. Each `syn` bit adds -1 when it is 1 (check unsatisfied) and +1 when it is 0 (check satisfied). The inversion metric is the sum of the correlation term and all COL_W of these terms.
- R5: On an iterate cycle where the metric is strictly below the current threshold, `hd_out` toggles and the threshold keeps its value.
- R6: On an iterate cycle where the metric is greater than or equal to the threshold, `hd_out` holds and the threshold becomes itself arithmetically shifted right by SHIFT. The threshold starts at INIT_THR at each frame start.
- R7: When the shifted threshold is greater than or equal to FLIP_THR, `quiet` rises at that edge. While `quiet` is 1, iterate strobes change nothing until the next `frame_start`.
- R8: `thr_hit` is 1 for exactly the one cycle that follows the edge at which `quiet` rises, and 0 at all other times.
- R9: A cycle with `iterate` low and `frame_start` low changes neither `hd_out` nor the node's threshold or quiescence.
- R10: When `frame_start` and `iterate` are both high, `frame_start` takes priority: no update step is taken and the frame reload happens instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Loads channel value, hard decision and initial threshold |
| ch_soft | input | 4 | Channel soft value: bit 3 sign, bits 2:0 magnitude |
| iterate | input | 1 | Strobe for one update step |
| syn | input | COL_W | Syndrome bits of the connected checks, 1 = unsatisfied |
| hd_out | output | 1 | Current hard decision to the check network |
| quiet | output | 1 | Node is quiescent for the rest of the frame |
| thr_hit | output | 1 | One-cycle pulse when the threshold reaches FLIP_THR |

## Verification
The embedded properties check these rules on every cycle:
- the frame reload;
- that a flip leaves the threshold alone;
- that a step without a flip shifts the threshold;
- that quiescence and idle cycles hold state;
- that the reached pulse coincides with the rise of quiescence.

Some behaviour shows up only through the outputs over several iterations, so only the bench scenarios can show it:
- the signed arithmetic of the metric, including the correlation sign after a flip;
- the equal-to-threshold boundary;
- that a channel input changed in mid-frame is ignored.

// File: rtl/atbf_pkg.sv
`timescale 1ns/1ps
package atbf_pkg;
    parameter int MAG_W = 3;
    parameter int SM_W  = MAG_W + 1;
    parameter int MET_W = 6;

    typedef logic signed [MET_W-1:0] met_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } sm_t;

    // Sign-magnitude to two's complement.
    function automatic met_t sm_to_tc(input sm_t v);
        met_t m;
        m = met_t'({{(MET_W-MAG_W){1'b0}}, v.mag});
        return v.neg ? -m : m;
    endfunction
endpackage

// File: rtl/atbf_corr.sv
`timescale 1ns/1ps
module atbf_corr
    import atbf_pkg::*;
(
    input  sm_t  chan,
    input  logic hd,
    output met_t corr
);
    sm_t signed_mag;

    // Inverter plus sign select: agreement keeps the magnitude positive.
    always_comb begin
        signed_mag.neg = hd ^ chan.neg;
        signed_mag.mag = chan.mag;
        corr           = sm_to_tc(signed_mag);
    end
endmodule

// File: rtl/atbf_metric.sv
`timescale 1ns/1ps
module atbf_metric
    import atbf_pkg::*;
#(
    parameter int COL_W = 3
) (
    input  met_t             corr,
    input  logic [COL_W-1:0] syn,
    output met_t             metric
);
    met_t term [COL_W];

    for (genvar g = 0; g < COL_W; g++) begin : g_bipolar
        assign term[g] = syn[g] ? met_t'(-1) : met_t'(1);
    end

    always_comb begin
        met_t acc;
        acc = corr;
        for (int i = 0; i < COL_W; i++) begin
            acc = acc + term[i];
        end
        metric = acc;
    end
endmodule

// File: rtl/atbf_decide.sv
`timescale 1ns/1ps
module atbf_decide
    import atbf_pkg::*;
#(
    parameter int SHIFT    = 1,
    parameter int FLIP_THR = -1
) (
    input  logic clk,
    input  logic rst,
    input  met_t metric,
    input  met_t thr,
    output logic do_flip,
    output met_t thr_next,
    output logic reach
);
    localparam met_t FLIP_T = met_t'(FLIP_THR);

    logic [MET_W:0] diff;

    // Sign of (metric - thr), one bit wider so it never overflows.
    assign diff     = {metric[MET_W-1], metric} - {thr[MET_W-1], thr};
    assign do_flip  = diff[MET_W];
    assign thr_next = thr >>> SHIFT;
    assign reach    = (thr_next >= FLIP_T);

    // R5: subtractor sign agrees with a signed comparison
    a_r5_sub_sign: assert property (@(posedge clk) disable iff (rst)
        do_flip == (metric < thr));
endmodule

// File: rtl/atbf_var_node.sv
`timescale 1ns/1ps
module atbf_var_node
    import atbf_pkg::*;
#(
    parameter int COL_W    = 3,
    parameter int SHIFT    = 1,
    parameter int INIT_THR = -12,
    parameter int FLIP_THR = -1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic [SM_W-1:0]  ch_soft,
    input  logic             iterate,
    input  logic [COL_W-1:0] syn,
    output logic             hd_out,
    output logic             quiet,
    output logic             thr_hit
);
    localparam met_t INIT_T = met_t'(INIT_THR);

    sm_t  ch_q;
    logic hd_q;
    met_t thr_q;
    logic quiet_q;
    logic hit_q;

    met_t corr;
    met_t metric;
    logic do_flip;
    met_t thr_next;
    logic reach;

    atbf_corr u_corr (
        .chan (ch_q),
        .hd   (hd_q),
        .corr (corr)
    );

    atbf_metric #(.COL_W(COL_W)) u_metric (
        .corr   (corr),
        .syn    (syn),
        .metric (metric)
    );

    atbf_decide #(.SHIFT(SHIFT), .FLIP_THR(FLIP_THR)) u_decide (
        .clk      (clk),
        .rst      (rst),
        .metric   (metric),
        .thr      (thr_q),
        .do_flip  (do_flip),
        .thr_next (thr_next),
        .reach    (reach)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q    <= '0;
            hd_q    <= 1'b0;
            thr_q   <= INIT_T;
            quiet_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            if (frame_start) begin
                ch_q    <= sm_t'(ch_soft);
                hd_q    <= ch_soft[SM_W-1];
                thr_q   <= INIT_T;
                quiet_q <= 1'b0;
            end else if (iterate && !quiet_q) begin
                if (do_flip) begin
                    hd_q <= ~hd_q;
                end else begin
                    thr_q <= thr_next;
                    if (reach) begin
                        quiet_q <= 1'b1;
                        hit_q   <= 1'b1;
                    end
                end
            end
        end
    end

    assign hd_out  = hd_q;
    assign quiet   = quiet_q;
    assign thr_hit = hit_q;

    // R2: frame reload takes the sign bit and clears quiescence
    a_r2_frame_load: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (hd_out == $past(ch_soft[SM_W-1])) && !quiet && (thr_q == INIT_T));

    // R5: a flip toggles the decision and leaves the threshold alone
    a_r5_flip_keeps_thr: assert property (@(posedge clk) disable iff (rst)
        (iterate && !frame_start && !quiet && do_flip) |=> (hd_out != $past(hd_out)) && $stable(thr_q));

    // R6: no flip shifts the threshold
    a_r6_shift: assert property (@(posedge clk) disable iff (rst)
        (iterate && !frame_start && !quiet && !do_flip) |=> (thr_q == ($past(thr_q) >>> SHIFT)) && $stable(hd_out));

    // R7: quiescence holds until a new frame
    a_r7_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (quiet && !frame_start) |=> quiet && $stable(hd_out) && $stable(thr_q));

    // R8: the reached pulse marks the rise of quiescence
    a_r8_hit_pulse: assert property (@(posedge clk) disable iff (rst)
        thr_hit == $rose(quiet));

    // R9: idle cycles change nothing
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (!iterate && !frame_start) |=> $stable(hd_out) && $stable(quiet) && $stable(thr_q));
endmodule

// File: tb/test_atbf_var_node.sv
`timescale 1ns/1ps
module test_atbf_var_node;
    localparam int TB_COL  = 4;
    localparam int TB_INIT = -12;
    localparam int TB_FLIP = -1;

    typedef struct {
        logic  hd;
        logic  q;
        logic  hit;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic [3:0]        ch_soft = '0;
    logic              iterate = 1'b0;
    logic [TB_COL-1:0] syn = '0;
    logic              hd_out;
    logic              quiet;
    logic              thr_hit;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;
    exp_t sb_q[$];

    // Bench model state
    bit         m_hd;
    bit         m_quiet;
    bit         m_hit;
    int         m_thr;
    logic [3:0] m_ch;

    always #2 clk = ~clk;

    atbf_var_node #(
        .COL_W(TB_COL), .SHIFT(1), .INIT_THR(TB_INIT), .FLIP_THR(TB_FLIP)
    ) i_atbf_var_node (
        .clk(clk), .rst(rst), .frame_start(frame_start), .ch_soft(ch_soft),
        .iterate(iterate), .syn(syn), .hd_out(hd_out), .quiet(quiet), .thr_hit(thr_hit)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (hd_out !== e.hd || quiet !== e.q || thr_hit !== e.hit) begin
            n_fail++;
            $display("FAIL %s: got hd=%b quiet=%b hit=%b, expected hd=%b quiet=%b hit=%b",
                     e.tag, hd_out, quiet, thr_hit, e.hd, e.q, e.hit);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the model's expectation
    task automatic step(input bit fs, input bit it, input logic [3:0] ch,
                        input logic [TB_COL-1:0] s, input string tag);
        exp_t e;
        int corr, met;
        @(negedge clk);
        frame_start = fs;
        iterate     = it;
        ch_soft     = ch;
        syn         = s;
        m_hit = 0;
        if (fs) begin
            m_ch = ch; m_hd = ch[3]; m_thr = TB_INIT; m_quiet = 0;
        end else if (it && !m_quiet) begin
            corr = (m_hd == m_ch[3]) ? int'(m_ch[2:0]) : -int'(m_ch[2:0]);
            met  = corr;
            for (int k = 0; k < TB_COL; k++) met += s[k] ? -1 : 1;
            if (met < m_thr) m_hd = !m_hd;
            else begin
                m_thr = m_thr >>> 1;
                if (m_thr >= TB_FLIP) begin m_quiet = 1; m_hit = 1; end
            end
        end
        e.hd = m_hd; e.q = m_quiet; e.hit = m_hit; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare one expectation per clock, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        n_checks++;
        if (hd_out !== 1'b0 || quiet !== 1'b0 || thr_hit !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got hd=%b quiet=%b hit=%b, expected 0 0 0", hd_out, quiet, thr_hit);
        end

        // Positive value 5, thresholds -12 -> -6 -> -3 -> -2 -> -1
        step(1, 0, 4'b0101, 4'b0000, "R2 load positive");
        step(0, 1, 4'b0101, 4'b0000, "R6 shift all satisfied");
        step(0, 1, 4'b0101, 4'b1111, "R6 shift all unsatisfied");
        step(0, 1, 4'b0101, 4'b1111, "R6 shift third");
        step(0, 1, 4'b0101, 4'b1111, "R7 R8 reach flip threshold");
        step(0, 0, 4'b0101, 4'b0000, "R8 pulse ends");
        step(0, 1, 4'b0101, 4'b1111, "R7 iterate ignored when quiet");

        // Negative value 6 held while the input changes to +1 (R3)
        step(1, 0, 4'b1110, 4'b0000, "R2 R10 load negative clears quiet");
        step(0, 1, 4'b0001, 4'b1111, "R3 held channel first step");
        step(0, 0, 4'b0001, 4'b1111, "R9 idle");
        step(0, 0, 4'b0001, 4'b0000, "R9 idle again");
        step(0, 1, 4'b0001, 4'b1111, "R3 held channel second step");
        step(0, 1, 4'b0001, 4'b1111, "R3 held channel no flip");
        step(0, 1, 4'b0001, 4'b1111, "R3 R7 quiet with held channel");

        // Magnitude 1: flip at threshold -2, correlation sign after flip
        step(1, 0, 4'b0001, 4'b0000, "R2 load magnitude one");
        step(0, 1, 4'b0001, 4'b0000, "R6 to -6");
        step(0, 1, 4'b0001, 4'b0000, "R6 to -3");
        step(0, 1, 4'b0001, 4'b0000, "R6 to -2");
        step(0, 1, 4'b0001, 4'b1111, "R5 flip below threshold");
        step(0, 1, 4'b0001, 4'b0111, "R4 negative correlation flips back");
        step(0, 1, 4'b0001, 4'b0111, "R4 positive correlation no flip");

        // Magnitude 2: metric equal to threshold does not flip
        step(1, 0, 4'b0010, 4'b0000, "R2 load magnitude two");
        step(0, 1, 4'b0010, 4'b0000, "R6 to -6 again");
        step(0, 1, 4'b0010, 4'b0000, "R6 to -3 again");
        step(0, 1, 4'b0010, 4'b1111, "R6 metric above threshold");
        step(0, 1, 4'b0010, 4'b1111, "R6 equal boundary no flip");

        // Frame start together with iterate
        step(1, 1, 4'b1011, 4'b1111, "R10 frame start wins");
        step(0, 1, 4'b1011, 4'b0000, "R10 threshold reloaded");
        step(0, 0, 4'b1011, 4'b0000, "R9 final idle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule